// File: doc/BRIEF.md
# 4:2:2 YCrCb Video Port Formatter

This block sits at the end of a camera pixel pipeline. It pulls full-resolution YCrCb pixels through a valid/ready handshake and drives a 4:2:2 digital video port. It generates the line and frame timing for one of three image sizes. It emits active-low horizontal and vertical sync, a line-active reference and a chroma-phase flag. On each pixel it keeps only the chroma component that the 4:2:2 phase calls for.

The port has two bus widths. In the wide mode, luma goes on an 8-bit Y bus and chroma on an 8-bit C bus, one pixel per clock. In the narrow mode, each pixel takes two clocks on the Y bus: first its chroma byte, then its luma byte, so the bytes run Cb, Y, Cr, Y. A monochrome switch replaces every chroma sample with the neutral code.

Image size, bus width and the monochrome switch are taken in during reset and at each frame boundary. A change to them takes effect from the next frame. Blanking lengths and sync placement are parameters. The clock is the pixel reference in the wide mode and twice the pixel rate in the narrow mode.

Top module: `ycc_port_fmt`

## Requirements
- R1: `fmt_sel` selects the active image size, which is taken in during reset and at each frame boundary. Code 0 gives CIF_W x CIF_H, code 1 gives QCIF_W x QCIF_H, code 2 gives WIDE_W x WIDE_H, and code 3 behaves as code 0. Each line is the active pixels followed by HBLANK pixel periods. Each frame is the active lines followed by VBLANK lines.
- R2: The outputs are registered. The output for a slot appears one clock after the slot is timed. `vid_href` is 1 exactly for the slots that carry active pixels.
- R3: In wide mode (`bus8_sel`=0) each active clock carries one pixel. `vid_y` carries its luma. `vid_c` carries its Cb when the pixel index within the line is even, and its Cr when the index is odd.
- R4: In narrow mode (`bus8_sel`=1) each pixel takes two clocks. The first clock puts the pixel's chroma byte on `vid_y`, chosen by the same even/odd rule as R3. The second clock puts its luma on `vid_y`. `vid_c` stays at 128.
- R5: `vid_crs` is 1 when the current pixel index within the line is odd (the chroma sample is Cr). It is 0 when the index is even (Cb), so it is 0 on the first active pixel. It is 0 during blanking.
- R6: During blanking `vid_y` is 16 and `vid_c` is 128.
- R7: `vid_hs_n` is low for HS_W pixel periods on every line, starting HS_OFF pixel periods after the active part ends. `vid_vs_n` is low for VS_LINES whole lines, starting VS_OFF lines after the last active line.
- R8: With `mono_sel`=1, every chroma sample on the port is 128. Luma is not affected.
- R9: `pix_ready` is 1, outside reset, exactly when the timing is on the first clock of an active pixel, and a pixel is taken when `pix_valid` is also 1. If `pix_valid` is 0 at that point, the pixel's luma is sent as 16 and its chroma as 128, while `vid_href` stays high.
- R10: A change to `fmt_sel`, `bus8_sel` or `mono_sel` in the middle of a frame has no effect until the next frame begins.
- R11: While `rst` is high, the outputs hold these values: `vid_y`=16, `vid_c`=128, `vid_crs`=0, `vid_href`=0, `vid_hs_n`=1, `vid_vs_n`=1, `pix_ready`=0. After release, timing starts at the first active pixel of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock (pixel rate, or twice it in narrow mode) |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Image size code |
| bus8_sel | input | 1 | 1 = narrow multiplexed bus, 0 = separate Y and C buses |
| mono_sel | input | 1 | 1 = monochrome (neutral chroma) |
| pix_valid | input | 1 | Upstream pixel present |
| pix_ready | output | 1 | Pixel taken this clock when valid |
| pix_y | input | 8 | Pixel luma |
| pix_cb | input | 8 | Pixel blue-difference chroma |
| pix_cr | input | 8 | Pixel red-difference chroma |
| vid_y | output | 8 | Luma bus, or multiplexed byte bus in narrow mode |
| vid_c | output | 8 | Chroma bus |
| vid_crs | output | 1 | Chroma phase: 1 = Cr, 0 = Cb |
| vid_href | output | 1 | High during active pixel output |
| vid_hs_n | output | 1 | Horizontal sync, active low |
| vid_vs_n | output | 1 | Vertical sync, active low |

## Verification
The embedded properties assume nothing about `pix_valid` or the pixel values. They rely only on the sync windows lying inside blanking, so the parameters must satisfy HS_OFF+HS_W <= HBLANK and VS_OFF+VS_LINES <= VBLANK. The stimulus keeps to that with small blanking parameters. It always presents data that depends on the pixel position, so every selected byte can be traced to its source. It drops `pix_valid` only on a chosen pixel, and it changes the mode inputs either under reset or in the middle of a frame.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  typedef enum logic [1:0] {
    FMT_CIF  = 2'd0,
    FMT_QCIF = 2'd1,
    FMT_WIDE = 2'd2
  } fmt_e;

  typedef struct packed {
    logic [1:0] fmt;
    logic       bus8;
    logic       mono;
  } cfg_t;

  localparam logic [7:0] Y_BLANK   = 8'd16;
  localparam logic [7:0] C_NEUTRAL = 8'd128;
endpackage

// File: rtl/vfmt_timing.sv
module vfmt_timing
  import vfmt_pkg::*;
#(
  parameter int CIF_W    = 352,
  parameter int CIF_H    = 288,
  parameter int QCIF_W   = 176,
  parameter int QCIF_H   = 144,
  parameter int WIDE_W   = 704,
  parameter int WIDE_H   = 288,
  parameter int HBLANK   = 160,
  parameter int HS_OFF   = 16,
  parameter int HS_W     = 64,
  parameter int VBLANK   = 25,
  parameter int VS_OFF   = 2,
  parameter int VS_LINES = 3
) (
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg_in,
  output cfg_t cfg_q,
  output logic active,
  output logic first_slot,
  output logic px_odd,
  output logic hs_win,
  output logic vs_win
);
  localparam int MAX_W = (CIF_W > QCIF_W) ? ((CIF_W > WIDE_W) ? CIF_W : WIDE_W)
                                          : ((QCIF_W > WIDE_W) ? QCIF_W : WIDE_W);
  localparam int MAX_H = (CIF_H > QCIF_H) ? ((CIF_H > WIDE_H) ? CIF_H : WIDE_H)
                                          : ((QCIF_H > WIDE_H) ? QCIF_H : WIDE_H);
  localparam int HCW = $clog2(2 * (MAX_W + HBLANK) + 1);
  localparam int VCW = $clog2(MAX_H + VBLANK + 1);

  logic [HCW-1:0] h, wsel, act_w, line_len, hs_lo, hs_hi;
  logic [VCW-1:0] v, hsel, frame_len, vs_lo, vs_hi;
  logic           line_end, frame_end;

  // size selection; the unlisted code falls back to CIF
  always_comb begin
    case (cfg_q.fmt)
      FMT_QCIF: begin wsel = HCW'(QCIF_W); hsel = VCW'(QCIF_H); end
      FMT_WIDE: begin wsel = HCW'(WIDE_W); hsel = VCW'(WIDE_H); end
      default:  begin wsel = HCW'(CIF_W);  hsel = VCW'(CIF_H);  end
    endcase
  end

  // horizontal limits in clock slots: doubled in narrow mode
  assign act_w    = wsel << cfg_q.bus8;
  assign line_len = (wsel + HCW'(HBLANK)) << cfg_q.bus8;
  assign hs_lo    = (wsel + HCW'(HS_OFF)) << cfg_q.bus8;
  assign hs_hi    = (wsel + HCW'(HS_OFF + HS_W)) << cfg_q.bus8;
  assign frame_len = hsel + VCW'(VBLANK);
  assign vs_lo     = hsel + VCW'(VS_OFF);
  assign vs_hi     = hsel + VCW'(VS_OFF + VS_LINES);

  assign line_end  = (h == line_len - HCW'(1));
  assign frame_end = line_end && (v == frame_len - VCW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      h     <= '0;
      v     <= '0;
      cfg_q <= cfg_in;
    end else if (line_end) begin
      h <= '0;
      if (frame_end) begin
        v     <= '0;
        cfg_q <= cfg_in;
      end else begin
        v <= v + VCW'(1);
      end
    end else begin
      h <= h + HCW'(1);
    end
  end

  assign active     = (v < hsel) && (h < act_w);
  assign first_slot = cfg_q.bus8 ? ~h[0] : 1'b1;
  assign px_odd     = cfg_q.bus8 ? h[1] : h[0];
  assign hs_win     = (h >= hs_lo) && (h < hs_hi);
  assign vs_win     = (v >= vs_lo) && (v < vs_hi);

  // sync windows must sit in blanking (R7)
  assert_vs_in_blank_R7: assert property (@(posedge clk) disable iff (rst)
    vs_win |-> !active);
  assert_hs_in_blank_R7: assert property (@(posedge clk) disable iff (rst)
    hs_win |-> !active);
endmodule

// File: rtl/vfmt_pixmux.sv
module vfmt_pixmux
  import vfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus8,
  input  logic       mono,
  input  logic       active,
  input  logic       first_slot,
  input  logic       px_odd,
  input  logic       hs_win,
  input  logic       vs_win,
  input  logic       in_valid,
  input  logic [7:0] in_y,
  input  logic [7:0] in_cb,
  input  logic [7:0] in_cr,
  output logic [7:0] y_o,
  output logic [7:0] c_o,
  output logic       crs_o,
  output logic       href_o,
  output logic       hs_n_o,
  output logic       vs_n_o
);
  logic       take, got;
  logic [7:0] chroma, luma_hold;

  assign take   = active & first_slot;
  assign got    = take & in_valid;
  assign chroma = mono ? C_NEUTRAL : (px_odd ? in_cr : in_cb);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o       <= Y_BLANK;
      c_o       <= C_NEUTRAL;
      crs_o     <= 1'b0;
      href_o    <= 1'b0;
      hs_n_o    <= 1'b1;
      vs_n_o    <= 1'b1;
      luma_hold <= Y_BLANK;
    end else begin
      href_o <= active;
      hs_n_o <= ~hs_win;
      vs_n_o <= ~vs_win;
      crs_o  <= active & px_odd;
      if (take) luma_hold <= got ? in_y : Y_BLANK;
      if (!active) begin
        y_o <= Y_BLANK;
        c_o <= C_NEUTRAL;
      end else if (!bus8) begin
        y_o <= got ? in_y : Y_BLANK;
        c_o <= got ? chroma : C_NEUTRAL;
      end else begin
        c_o <= C_NEUTRAL;
        y_o <= first_slot ? (got ? chroma : C_NEUTRAL) : luma_hold;
      end
    end
  end

  assert_blank_levels_R6: assert property (@(posedge clk) disable iff (rst)
    !href_o |-> (y_o == Y_BLANK) && (c_o == C_NEUTRAL));
  assert_line_starts_cb_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(href_o) |-> !crs_o);
  assert_crs_toggles_R5: assert property (@(posedge clk) disable iff (rst)
    (href_o && $past(href_o) && !bus8) |-> (crs_o != $past(crs_o)));
  assert_neutral_chroma_R8: assert property (@(posedge clk) disable iff (rst)
    (href_o && (mono || bus8)) |-> (c_o == C_NEUTRAL));
  assert_hs_not_active_R7: assert property (@(posedge clk) disable iff (rst)
    !hs_n_o |-> !href_o);
endmodule

// File: rtl/ycc_port_fmt.sv
module ycc_port_fmt
  import vfmt_pkg::*;
#(
  parameter int CIF_W    = 352,
  parameter int CIF_H    = 288,
  parameter int QCIF_W   = 176,
  parameter int QCIF_H   = 144,
  parameter int WIDE_W   = 704,
  parameter int WIDE_H   = 288,
  parameter int HBLANK   = 160,
  parameter int HS_OFF   = 16,
  parameter int HS_W     = 64,
  parameter int VBLANK   = 25,
  parameter int VS_OFF   = 2,
  parameter int VS_LINES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] fmt_sel,
  input  logic       bus8_sel,
  input  logic       mono_sel,
  input  logic       pix_valid,
  output logic       pix_ready,
  input  logic [7:0] pix_y,
  input  logic [7:0] pix_cb,
  input  logic [7:0] pix_cr,
  output logic [7:0] vid_y,
  output logic [7:0] vid_c,
  output logic       vid_crs,
  output logic       vid_href,
  output logic       vid_hs_n,
  output logic       vid_vs_n
);
  cfg_t cfg_in, cfg_q;
  logic active, first_slot, px_odd, hs_win, vs_win;

  assign cfg_in = '{fmt: fmt_sel, bus8: bus8_sel, mono: mono_sel};

  vfmt_timing #(
    .CIF_W(CIF_W), .CIF_H(CIF_H), .QCIF_W(QCIF_W), .QCIF_H(QCIF_H),
    .WIDE_W(WIDE_W), .WIDE_H(WIDE_H), .HBLANK(HBLANK), .HS_OFF(HS_OFF),
    .HS_W(HS_W), .VBLANK(VBLANK), .VS_OFF(VS_OFF), .VS_LINES(VS_LINES)
  ) u_timing (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_q(cfg_q),
    .active(active), .first_slot(first_slot), .px_odd(px_odd),
    .hs_win(hs_win), .vs_win(vs_win)
  );

  assign pix_ready = active & first_slot & ~rst;

  vfmt_pixmux u_mux (
    .clk(clk), .rst(rst), .bus8(cfg_q.bus8), .mono(cfg_q.mono),
    .active(active), .first_slot(first_slot), .px_odd(px_odd),
    .hs_win(hs_win), .vs_win(vs_win), .in_valid(pix_valid),
    .in_y(pix_y), .in_cb(pix_cb), .in_cr(pix_cr),
    .y_o(vid_y), .c_o(vid_c), .crs_o(vid_crs), .href_o(vid_href),
    .hs_n_o(vid_hs_n), .vs_n_o(vid_vs_n)
  );

  // a taken pixel is on the port one clock later
  assert_ready_to_href_R9: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> vid_href);
endmodule

// File: tb/tb_ycc_port_fmt.sv
`timescale 1ns/1ps
module tb_ycc_port_fmt;
  localparam int CW = 12, CH = 4, QW = 6, QH = 2, WW = 24, WH = 4;
  localparam int HB = 8, HSO = 2, HSW = 3, VB = 4, VSO = 1, VSL = 2;

  // {fmt[31:30], bus8[29], mono[28], gap_px[27:22], gap_line[21:18], exp_w[17:10], exp_h[9:6]}
  localparam int NV = 7;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {2'd0, 1'b0, 1'b0, 6'd5,  4'd1,  8'd12, 4'd4, 6'd0},
    {2'd1, 1'b0, 1'b0, 6'd63, 4'd15, 8'd6,  4'd2, 6'd0},
    {2'd2, 1'b0, 1'b1, 6'd3,  4'd0,  8'd24, 4'd4, 6'd0},
    {2'd0, 1'b1, 1'b0, 6'd2,  4'd2,  8'd12, 4'd4, 6'd0},
    {2'd1, 1'b1, 1'b1, 6'd63, 4'd15, 8'd6,  4'd2, 6'd0},
    {2'd3, 1'b0, 1'b0, 6'd63, 4'd15, 8'd12, 4'd4, 6'd0},
    {2'd2, 1'b1, 1'b0, 6'd23, 4'd3,  8'd24, 4'd4, 6'd0}
  };

  logic clk = 0, rst = 1;
  logic [1:0] fmt_sel = 0;
  logic bus8_sel = 0, mono_sel = 0, pix_valid = 0;
  logic [7:0] pix_y = 0, pix_cb = 0, pix_cr = 0;
  logic pix_ready, vid_crs, vid_href, vid_hs_n, vid_vs_n;
  logic [7:0] vid_y, vid_c;

  int total = 0, bad = 0;
  int mh = 0, mv = 0, gap_px = 63, gap_ln = 15, href_cnt = 0;
  logic [1:0] mfmt = 0;
  logic m8 = 0, mmono = 0;

  always #2.5 clk = ~clk;

  ycc_port_fmt #(
    .CIF_W(CW), .CIF_H(CH), .QCIF_W(QW), .QCIF_H(QH), .WIDE_W(WW), .WIDE_H(WH),
    .HBLANK(HB), .HS_OFF(HSO), .HS_W(HSW), .VBLANK(VB), .VS_OFF(VSO), .VS_LINES(VSL)
  ) dut (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .bus8_sel(bus8_sel), .mono_sel(mono_sel),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_y(pix_y), .pix_cb(pix_cb),
    .pix_cr(pix_cr), .vid_y(vid_y), .vid_c(vid_c), .vid_crs(vid_crs),
    .vid_href(vid_href), .vid_hs_n(vid_hs_n), .vid_vs_n(vid_vs_n)
  );

  function automatic int w_of(input logic [1:0] f);
    return (f == 2'd1) ? QW : (f == 2'd2) ? WW : CW;
  endfunction
  function automatic int h_of(input logic [1:0] f);
    return (f == 2'd1) ? QH : (f == 2'd2) ? WH : CH;
  endfunction
  function automatic int flen(input logic [1:0] f, input logic b);
    return (w_of(f) + HB) * (b ? 2 : 1) * (h_of(f) + VB);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, what, act, exp, mh, mv);
    end
  endtask

  task automatic drive_slot();
    int k = m8 ? 2 : 1;
    int px = mh / k;
    bit act = (mv < h_of(mfmt)) && (mh < w_of(mfmt) * k);
    pix_valid = act ? !(px == gap_px && mv == gap_ln) : 1'b1;
    pix_y  = 8'(32 + px + 8 * mv);
    pix_cb = 8'(80 + px);
    pix_cr = 8'(160 + px);
  endtask

  // expected port values for model slot (mh, mv) under the model's frame config
  task automatic check_slot();
    int k = m8 ? 2 : 1;
    int w = w_of(mfmt), hh = h_of(mfmt);
    int px = mh / k, sub = mh % k;
    bit act = (mv < hh) && (mh < w * k);
    bit vld = !(px == gap_px && mv == gap_ln);
    int ey, ec, chroma;
    string tg;
    bit hsw = (mh >= (w + HSO) * k) && (mh < (w + HSO + HSW) * k);
    bit vsw = (mv >= hh + VSO) && (mv < hh + VSO + VSL);
    chroma = mmono ? 128 : ((px % 2) ? 160 + px : 80 + px);
    if (!act) begin
      ey = 16; ec = 128; tg = "R6";
    end else if (!m8) begin
      ey = vld ? (32 + px + 8 * mv) % 256 : 16;
      ec = vld ? chroma : 128;
      tg = !vld ? "R9" : (mmono ? "R8" : "R3");
    end else begin
      ec = 128;
      ey = (sub == 0) ? (vld ? chroma : 128) : (vld ? (32 + px + 8 * mv) % 256 : 16);
      tg = !vld ? "R9" : (mmono ? "R8" : "R4");
    end
    chk("R2", "vid_href", int'(vid_href), int'(act));
    chk(tg, "vid_y", int'(vid_y), ey);
    chk(tg, "vid_c", int'(vid_c), ec);
    chk("R5", "vid_crs", int'(vid_crs), act ? px % 2 : 0);
    chk("R7", "vid_hs_n", int'(vid_hs_n), int'(!hsw));
    chk("R7", "vid_vs_n", int'(vid_vs_n), int'(!vsw));
    if (vid_href) href_cnt++;
  endtask

  task automatic advance();
    int k = m8 ? 2 : 1;
    mh++;
    if (mh == (w_of(mfmt) + HB) * k) begin
      mh = 0;
      mv++;
      if (mv == h_of(mfmt) + VB) begin
        mv = 0;
        mfmt = fmt_sel; m8 = bus8_sel; mmono = mono_sel;
      end
    end
  endtask

  task automatic cycle();
    int k;
    @(posedge clk);
    @(negedge clk);
    check_slot();
    advance();
    k = m8 ? 2 : 1;
    chk("R9", "pix_ready", int'(pix_ready),
        int'((mv < h_of(mfmt)) && (mh < w_of(mfmt) * k) && (mh % k == 0)));
    drive_slot();
  endtask

  task automatic do_reset(input logic [1:0] f, input logic b, input logic m);
    @(negedge clk);
    fmt_sel = f; bus8_sel = b; mono_sel = m;
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset vid_y", int'(vid_y), 16);
    chk("R11", "reset vid_c", int'(vid_c), 128);
    chk("R11", "reset vid_crs", int'(vid_crs), 0);
    chk("R11", "reset vid_href", int'(vid_href), 0);
    chk("R11", "reset vid_hs_n", int'(vid_hs_n), 1);
    chk("R11", "reset vid_vs_n", int'(vid_vs_n), 1);
    chk("R11", "reset pix_ready", int'(pix_ready), 0);
    mh = 0; mv = 0; mfmt = f; m8 = b; mmono = m;
    drive_slot();
    rst = 0;
    href_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // table walk: one full frame per vector (R1..R9, R11)
    for (int i = 0; i < NV; i++) begin
      logic [31:0] vv = VEC[i];
      int k = vv[29] ? 2 : 1;
      gap_px = int'(vv[27:22]);
      gap_ln = int'(vv[21:18]);
      do_reset(vv[31:30], vv[29], vv[28]);
      repeat (flen(vv[31:30], vv[29])) cycle();
      chk("R1", "active samples per frame", href_cnt, int'(vv[17:10]) * k * int'(vv[9:6]));
    end

    // R10: mode change mid-frame only applies from the next frame
    gap_px = 63; gap_ln = 15;
    do_reset(2'd0, 1'b0, 1'b0);
    repeat (30) cycle();
    fmt_sel = 2'd1; bus8_sel = 1'b1; mono_sel = 1'b1;
    repeat (flen(2'd0, 1'b0) - 30) cycle();
    chk("R10", "first frame keeps old size", href_cnt, CW * CH);
    href_cnt = 0;
    repeat (flen(2'd1, 1'b1)) cycle();
    chk("R10", "next frame uses new size", href_cnt, QW * 2 * QH);

    // R11: reset in mid-frame restarts at the first active pixel
    repeat (7) cycle();
    do_reset(2'd2, 1'b0, 1'b0);
    cycle();
    chk("R11", "first slot after reset active", int'(vid_href), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule